// File: doc/BRIEF.md
# Serial Receive Channel with Break-Aware Queue

This block receives asynchronous serial characters on one line. An enable pulse at sixteen times the bit rate times its sampling. Software sets the character length from 5 to 8 bits and chooses one of four handling modes for the slot after the data bits: no slot, a checked even or odd parity bit, a parity bit that must equal a fixed value, or an address/data marker for multidrop links. Every finished character goes into a 16-slot queue. Each slot also holds three status flags: break, missing stop bit, and parity. If the queue is full, one more character can wait in a holding register. Characters that arrive after that raise a sticky overrun flag.

A break is a line held low for a whole character, including the stop bit. It takes exactly one queue slot. After a break the receiver stores nothing more until the line has stayed high for half a bit. A one-cycle event marks both the start and the end of the break. The processor reads the head of the queue through a single strobe. A separate command pulse clears the overrun flag.

Top module: `rxchan_top`

## Requirements
- R1: A falling edge begins a start bit only if the line is still low at the 8th oversample tick. A low pulse shorter than that stores nothing.
- R2: Data bits arrive least-significant bit first. The count is cfg_len+5 (0→5 … 3→8 bits). Data bits above the programmed length read as zero.
- R3: cfg_par_mode selects the slot after the data bits. 0 means no slot. 1 means a checked parity bit: cfg_par_sel 0 gives even parity and 1 gives odd. 2 means the bit must equal cfg_par_sel. 3 is multidrop: the received bit is stored as the parity flag. In modes 1 and 2, rd_pe is 1 when the check fails.
- R4: rd_fe is 1 when the stop bit, sampled at its middle, is low.
- R5: A character with all data bits zero, a zero parity slot (if present) and a low stop bit is stored as one entry with rd_brk=1, rd_fe=1 and data zero.
- R6: After a break no further entry is stored until the line has been high for 8 consecutive ticks. Any low tick restarts that count.
- R7: brk_evt pulses for one cycle when a break is stored, and once more when the line has been high for the 8 ticks that end the break.
- R8: If the line drops low in the middle of a character and stays low, that character is stored with rd_fe=1. It is followed by one break entry.
- R9: The queue holds 16 entries and shows its head on rd_data/rd_brk/rd_fe/rd_pe, with rx_ready high when it is not empty. rd_stb removes the head. On an empty queue all read outputs are zero and a strobe changes nothing.
- R10: A character that completes while the queue is full waits in a holding register. It enters the queue in the same cycle as the next read.
- R11: rx_full is high while all 16 slots are occupied. With a character waiting, it stays high after the first read and clears after the second.
- R12: A character that completes while the queue is full and the holding register is occupied sets ovr and is discarded. ovr stays set until an err_clr pulse.
- R13: After reset rx_ready, rx_full, ovr, brk_evt and all read outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversample enable, 16 per bit time |
| rxd | input | 1 | Serial input line, high when idle |
| cfg_len | input | 2 | Character length code (bits = code+5) |
| cfg_par_mode | input | 2 | Slot mode: none, parity, forced, multidrop |
| cfg_par_sel | input | 1 | Odd parity select / forced bit value |
| rd_stb | input | 1 | Remove the queue head |
| err_clr | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Head data, zero when empty |
| rd_brk | output | 1 | Head break flag |
| rd_fe | output | 1 | Head missing-stop flag |
| rd_pe | output | 1 | Head parity flag or multidrop marker |
| rx_ready | output | 1 | Queue not empty |
| rx_full | output | 1 | All 16 slots occupied |
| ovr | output | 1 | Sticky overrun |
| brk_evt | output | 1 | Break start/end pulse |

## Verification
The assertions assume that rxd holds each level for whole bit times counted in os_tick pulses. They also assume the configuration inputs change only while the line is idle. The bench drives os_tick high on every clock and holds each bit for exactly 16 clocks. It changes cfg_len, cfg_par_mode and cfg_par_sel only between characters. The assertions also assume that rd_stb and err_clr are single-cycle pulses; the bench drives them that way and never asserts them while a character is completing.

// File: rtl/rxchan_pkg.sv
package rxchan_pkg;
    // Handling of the slot that follows the data bits
    typedef enum logic [1:0] {
        PAR_NONE      = 2'd0,
        PAR_NORMAL    = 2'd1,
        PAR_FORCED    = 2'd2,
        PAR_MULTIDROP = 2'd3
    } par_mode_e;

    // Receiver sequencing states
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRKWAIT
    } fr_state_e;

    // One queue slot: 11 bits of flags and data
    typedef struct packed {
        logic       brk;
        logic       fe;
        logic       pe;
        logic [7:0] data;
    } rx_entry_t;
endpackage

// File: rtl/rx_framer.sv
// rx_framer: synchronises the line, qualifies start bits at mid-bit, collects
// data and the optional slot bit, checks the stop bit and emits one entry per
// character. After a break it waits for half a bit of marking line.
// Assumes os_tick pulses OS_RATE times per bit and config is stable per frame.
module rx_framer
    import rxchan_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par_mode,
    input  logic       cfg_par_sel,
    output logic       push,
    output rx_entry_t  push_entry,
    output logic       brk_evt
);
    localparam int CNT_W = $clog2(OS_RATE);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OS_RATE - 1);

    logic [1:0]       sync_q;
    logic             rxd_s;
    fr_state_e        state;
    logic [CNT_W-1:0] tick_cnt;
    logic [CNT_W-1:0] mark_cnt;
    logic [2:0]       bit_idx;
    logic [2:0]       last_idx;
    logic [7:0]       shreg;
    logic             par_bit;
    logic             brk_now;
    logic             pe_now;
    par_mode_e        pmode;

    assign pmode    = par_mode_e'(cfg_par_mode);
    assign last_idx = 3'(cfg_len) + 3'd4;
    assign rxd_s    = sync_q[1];

    // Two-stage synchroniser on the serial line
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // Parity flag for the character now in the shift register
    always_comb begin
        case (pmode)
            PAR_NORMAL:    pe_now = par_bit != ((^shreg) ^ cfg_par_sel);
            PAR_FORCED:    pe_now = par_bit != cfg_par_sel;
            PAR_MULTIDROP: pe_now = par_bit;
            default:       pe_now = 1'b0;
        endcase
    end

    // Break: everything low including the stop bit
    assign brk_now = (shreg == 8'd0) && !par_bit && !rxd_s;

    // Frame sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            tick_cnt   <= '0;
            mark_cnt   <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            push       <= 1'b0;
            push_entry <= '0;
            brk_evt    <= 1'b0;
        end else begin
            push    <= 1'b0;
            brk_evt <= 1'b0;
            if (os_tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!rxd_s) begin
                            state    <= ST_START;
                            tick_cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (tick_cnt == MID) begin
                            tick_cnt <= '0;
                            if (!rxd_s) begin
                                state   <= ST_DATA;
                                bit_idx <= '0;
                                shreg   <= '0;
                                par_bit <= 1'b0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (tick_cnt == LAST) begin
                            tick_cnt       <= '0;
                            shreg[bit_idx] <= rxd_s;
                            if (bit_idx == last_idx)
                                state <= (pmode == PAR_NONE) ? ST_STOP : ST_PAR;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (tick_cnt == LAST) begin
                            tick_cnt <= '0;
                            par_bit  <= rxd_s;
                            state    <= ST_STOP;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (tick_cnt == LAST) begin
                            tick_cnt   <= '0;
                            push       <= 1'b1;
                            push_entry <= '{brk: brk_now, fe: !rxd_s,
                                            pe: pe_now, data: shreg};
                            if (brk_now) begin
                                state    <= ST_BRKWAIT;
                                brk_evt  <= 1'b1;
                                mark_cnt <= '0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    ST_BRKWAIT: begin
                        if (rxd_s) begin
                            if (mark_cnt == MID) begin
                                state   <= ST_IDLE;
                                brk_evt <= 1'b1;
                            end else begin
                                mark_cnt <= mark_cnt + 1'b1;
                            end
                        end else begin
                            mark_cnt <= '0;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R6
    brkwait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRKWAIT) |=> !push);

    // R5
    brk_enters_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_entry.brk) |-> (state == ST_BRKWAIT));

    // R7
    brk_evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> !brk_evt);
endmodule

// File: rtl/rx_fifo.sv
// rx_fifo: circular queue of DEPTH entries with a zero-valued head when empty.
// Assumes the writer never pushes into a full queue unless it pops that cycle.
module rx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W:0]   CNT_MAX = (PTR_W + 1)'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W:0]   count;
    logic             do_rd, do_wr;

    assign empty   = (count == '0);
    assign full    = (count == CNT_MAX);
    assign do_rd   = rd_en && !empty;
    assign do_wr   = wr_en && (!full || do_rd);
    assign rd_data = empty ? '0 : mem[rd_ptr];

    // Storage write
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!full || rd_en));

    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> empty);
endmodule

// File: rtl/rx_hold.sv
// rx_hold: steers finished characters into the queue, parks one in a holding
// register when the queue is full, refills the queue from it on a read, and
// raises the sticky overrun flag when both are occupied.
// Assumes new_valid is a one-cycle pulse per character.
module rx_hold
    import rxchan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      new_valid,
    input  rx_entry_t new_entry,
    input  logic      rd_req,
    input  logic      err_clr,
    input  logic      fifo_empty,
    input  logic      fifo_full,
    output logic      fifo_wr_en,
    output rx_entry_t fifo_wr_data,
    output logic      ovr
);
    rx_entry_t hold_q;
    logic      hold_v;
    logic      pop;

    assign pop = rd_req && !fifo_empty;

    // Select what enters the queue this cycle
    always_comb begin
        if (hold_v) begin
            fifo_wr_en   = pop;
            fifo_wr_data = hold_q;
        end else begin
            fifo_wr_en   = new_valid && (!fifo_full || pop);
            fifo_wr_data = new_entry;
        end
    end

    // Holding register and overrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            hold_v <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            if (err_clr) ovr <= 1'b0;
            if (hold_v) begin
                if (pop) begin
                    hold_v <= new_valid;
                    if (new_valid) hold_q <= new_entry;
                end else if (new_valid) begin
                    ovr <= 1'b1;
                end
            end else if (new_valid && fifo_full && !pop) begin
                hold_v <= 1'b1;
                hold_q <= new_entry;
            end
        end
    end

    // R12
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !err_clr) |=> ovr);

    // R10
    hold_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_v |-> fifo_full);

    // R11
    refill_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_v && pop) |=> fifo_full);
endmodule

// File: rtl/rxchan_top.sv
// rxchan_top: one serial receive channel. Connects the framer, the holding
// stage and the queue, and presents the queue head to the reader.
// Assumes rd_stb and err_clr are single-cycle pulses.
module rxchan_top
    import rxchan_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int DEPTH   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par_mode,
    input  logic       cfg_par_sel,
    input  logic       rd_stb,
    input  logic       err_clr,
    output logic [7:0] rd_data,
    output logic       rd_brk,
    output logic       rd_fe,
    output logic       rd_pe,
    output logic       rx_ready,
    output logic       rx_full,
    output logic       ovr,
    output logic       brk_evt
);
    localparam int ENTRY_W = $bits(rx_entry_t);

    logic      fr_push;
    rx_entry_t fr_entry;
    logic      q_wr_en;
    rx_entry_t q_wr_data;
    logic [ENTRY_W-1:0] q_head;
    rx_entry_t head;
    logic      q_empty, q_full;

    rx_framer #(.OS_RATE(OS_RATE)) u_framer (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_mode(cfg_par_mode),
        .cfg_par_sel(cfg_par_sel), .push(fr_push), .push_entry(fr_entry),
        .brk_evt(brk_evt)
    );

    rx_hold u_hold (
        .clk(clk), .rst_n(rst_n), .new_valid(fr_push), .new_entry(fr_entry),
        .rd_req(rd_stb), .err_clr(err_clr), .fifo_empty(q_empty),
        .fifo_full(q_full), .fifo_wr_en(q_wr_en), .fifo_wr_data(q_wr_data),
        .ovr(ovr)
    );

    rx_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(q_wr_en), .wr_data(q_wr_data),
        .rd_en(rd_stb), .rd_data(q_head), .empty(q_empty), .full(q_full)
    );

    assign head     = rx_entry_t'(q_head);
    assign rd_data  = head.data;
    assign rd_brk   = head.brk;
    assign rd_fe    = head.fe;
    assign rd_pe    = head.pe;
    assign rx_ready = !q_empty;
    assign rx_full  = q_full;
endmodule

// File: tb/rxchan_top_test.sv
module rxchan_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;
    // {len[1:0], mode[1:0], sel, data[7:0], slot bit, stop bit, exp pe, exp fe}
    localparam logic [16:0] VECS [NV] = '{
        {2'd3, 2'd0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd0, 2'd0, 1'b0, 8'h15, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd2, 2'd1, 1'b0, 8'h53, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd2, 2'd1, 1'b0, 8'h53, 1'b1, 1'b1, 1'b1, 1'b0},
        {2'd1, 2'd1, 1'b1, 8'h2C, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd3, 2'd2, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b1, 1'b0},
        {2'd3, 2'd3, 1'b0, 8'h81, 1'b1, 1'b1, 1'b1, 1'b0},
        {2'd3, 2'd3, 1'b0, 8'h7E, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd3, 2'd0, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic clk = 0, rst_n = 0, os_tick = 1, rxd = 1;
    logic [1:0] cfg_len = 2'd3, cfg_par_mode = 2'd0;
    logic cfg_par_sel = 0, rd_stb = 0, err_clr = 0;
    logic [7:0] rd_data;
    logic rd_brk, rd_fe, rd_pe, rx_ready, rx_full, ovr, brk_evt;
    int checks = 0, fails = 0, brk_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rxchan_top uut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_mode(cfg_par_mode),
        .cfg_par_sel(cfg_par_sel), .rd_stb(rd_stb), .err_clr(err_clr),
        .rd_data(rd_data), .rd_brk(rd_brk), .rd_fe(rd_fe), .rd_pe(rd_pe),
        .rx_ready(rx_ready), .rx_full(rx_full), .ovr(ovr), .brk_evt(brk_evt)
    );

    always @(negedge clk) if (rst_n && brk_evt) brk_cnt++;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int cycles);
        rxd = v;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic send(input int len_code, input logic [7:0] d,
                        input bit has_slot, input logic sb, input logic stp);
        hold_line(1'b0, 16);
        for (int i = 0; i < len_code + 5; i++) hold_line(d[i], 16);
        if (has_slot) hold_line(sb, 16);
        hold_line(stp, 16);
        hold_line(1'b1, 16);
    endtask

    task automatic pop();
        rd_stb = 1;
        @(negedge clk);
        rd_stb = 0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R13 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [16:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13 reset state
        check("R13 rx_ready", rx_ready, 0);
        check("R13 rx_full", rx_full, 0);
        check("R13 ovr", ovr, 0);
        check("R13 brk_evt", brk_evt, 0);
        check("R13 rd_data", {rd_brk, rd_fe, rd_pe, rd_data}, 0);

        // Vector table walk: R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            cfg_len = v[16:15];
            cfg_par_mode = v[14:13];
            cfg_par_sel = v[12];
            send(int'(v[16:15]), v[11:4], v[14:13] != 2'd0, v[3], v[2]);
            hold_line(1'b1, 32);
            check("R9 ready", rx_ready, 1);
            check("R2 data", rd_data, v[11:4]);
            check("R3 pe", rd_pe, v[1]);
            check("R4 fe", rd_fe, v[0]);
            check("R5 brk", rd_brk, 0);
            pop();
            check("R9 drained", rx_ready, 0);
        end

        cfg_len = 2'd3; cfg_par_mode = 2'd0; cfg_par_sel = 0;

        // R1 false start
        hold_line(1'b0, 5);
        hold_line(1'b1, 400);
        check("R1 false start", rx_ready, 0);

        // R9 empty read returns zero and leaves pointers
        pop();
        check("R9 empty data", {rd_brk, rd_fe, rd_pe, rd_data}, 0);
        send(3, 8'h5A, 0, 0, 1);
        hold_line(1'b1, 16);
        check("R9 head after empty read", rd_data, 8'h5A);
        pop();
        check("R9 single entry", rx_ready, 0);

        // R5 R6 R7 break with short marking glitch
        brk_cnt = 0;
        hold_line(1'b0, 240);
        check("R7 break start event", brk_cnt, 1);
        check("R5 break stored", rx_ready, 1);
        hold_line(1'b1, 4);
        hold_line(1'b0, 160);
        check("R6 no end on short mark", brk_cnt, 1);
        hold_line(1'b1, 40);
        check("R7 break end event", brk_cnt, 2);
        check("R5 break entry", {rd_brk, rd_fe, rd_data}, {2'b11, 8'h00});
        pop();
        check("R6 only one entry", rx_ready, 0);

        // R8 break beginning mid-character
        brk_cnt = 0;
        hold_line(1'b0, 16);
        hold_line(1'b1, 32);
        hold_line(1'b0, 320);
        hold_line(1'b1, 40);
        check("R8 events", brk_cnt, 2);
        check("R8 first entry", {rd_brk, rd_fe, rd_data}, {2'b01, 8'h03});
        pop();
        check("R8 second entry brk", {rd_brk, rd_data}, {1'b1, 8'h00});
        pop();
        check("R8 drained", rx_ready, 0);

        // R10 R11 R12 fill, hold, overrun
        for (int i = 0; i < 16; i++) send(3, 8'(i), 0, 0, 1);
        check("R11 full at 16", rx_full, 1);
        send(3, 8'd16, 0, 0, 1);
        check("R12 no ovr with hold free", ovr, 0);
        send(3, 8'd17, 0, 0, 1);
        check("R12 ovr set", ovr, 1);
        pop();
        check("R11 full after first read", rx_full, 1);
        pop();
        check("R11 clear after second read", rx_full, 0);
        for (int i = 2; i < 16; i++) pop();
        check("R10 held char reaches head", rd_data, 8'd16);
        pop();
        check("R12 newest dropped", rx_ready, 0);
        check("R12 ovr sticky", ovr, 1);
        err_clr = 1;
        @(negedge clk);
        err_clr = 0;
        @(negedge clk);
        check("R12 ovr cleared", ovr, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule